// File: doc/BRIEF.md
# Four-Channel Serial DAC Register Front End

This block is the digital front end of a four-channel, 12-bit digital-to-analog converter. A host writes 16-bit words over a three-wire serial link made of a data line, a serial clock and an active-low select. The bits go into a shift register. A separate active-low load strobe then copies the 12-bit data field of that word into one of four channel registers. The two address bits at the head of the word pick the channel. The four channel registers drive the converter ladders directly.

An asynchronous active-low clear forces all four channel registers to a preset value. A clear-select pin chooses the preset: midscale or zero. The clear never touches the shift register, so a word already shifted in can still be loaded after the clear is released. All serial and strobe inputs are sampled into the block clock domain through a synchronizer chain. Edges are then detected there.

Top module: `sdac_quad_if`

## Requirements
- R1: A word is 16 bits long and is sent MSB first. Bits 15:14 are the channel address (bit 15 is sent first). Bits 13:12 are reserved and have no effect. Bits 11:0 are the data. Address values 0, 1, 2 and 3 select channel outputs 0, 1, 2 and 3.
- R2: One bit from `sdiIn` is shifted in on each rising edge of `sclkIn` that occurs while `selN` is low. While `selN` is high, activity on `sclkIn` and `sdiIn` leaves the shift register unchanged.
- R3: A falling edge on `ldN` writes the data field into the addressed channel, whatever level `selN` has at that time. Holding `ldN` low causes no further writes.
- R4: A load changes only the addressed channel. The other three channels keep their values.
- R5: While `clrN` is low, all four channels read 0x800 if `clrSel` is 1 and 0x000 if `clrSel` is 0. This takes effect without waiting for a clock edge.
- R6: A clear leaves the shift register contents unchanged.
- R7: A clear takes priority over a load. A load edge that occurs while `clrN` is low is lost, and the channels keep the preset after the clear is released.
- R8: After reset, every channel holds the preset chosen by `clrSel`, and the shift register holds zero.
- R9: When more than 16 bits are shifted in before a load, only the last 16 bits make up the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| sclkIn | input | 1 | Serial clock |
| selN | input | 1 | Active-low serial select |
| sdiIn | input | 1 | Serial data |
| ldN | input | 1 | Active-low load strobe; acts on its falling edge |
| clrN | input | 1 | Asynchronous active-low clear of the channel registers |
| clrSel | input | 1 | Clear preset choice: 1 gives midscale, 0 gives zero |
| chanOut | output | 4x12 | Channel register values; element i is channel i |

## Verification
The bench attacks the following corner cases, and each one catches a specific kind of fault:
- Serial clock pulses sent with select high. A design that ignored the select would shift them in and load a corrupted word.
- Loads issued with select both high and low. This catches a load that was wrongly gated by the select.
- Words longer than 16 bits. A design that counted bits instead of keeping the last 16 would store the wrong word.
- A clear asserted before the load, followed by a reload of the same word after the clear. A clear that wiped the shift register would then load zero into the channel.
- A load edge issued while the clear is held. A design that let the load through, or that kept it pending, would move a channel away from the preset.
- Each load is checked against all four channels, so a stray write to a neighbour channel also shows up.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  // Strobes sent from the control module to the datapath; each lasts one cycle.
  typedef struct packed {
    logic shift;  // take one serial bit
    logic bitIn;  // value of that bit
    logic load;   // commit data field to the addressed channel
  } strobe_t;
endpackage

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkIn,
  input  logic    selN,
  input  logic    sdiIn,
  input  logic    ldN,
  output strobe_t strobe
);
  // Vector order: {serial clock, select, data, load}
  localparam int VEC_W = 4;
  localparam logic [VEC_W-1:0] IDLE_VEC = 4'b0101;
  localparam int I_SCLK = 3;
  localparam int I_SEL  = 2;
  localparam int I_SDI  = 1;
  localparam int I_LD   = 0;

  logic [VEC_W-1:0] stage [SYNC_STAGES];
  logic [VEC_W-1:0] nowVec;
  logic [VEC_W-1:0] prevVec;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stage[s] <= IDLE_VEC;
        end else begin
          if (s == 0) stage[s] <= {sclkIn, selN, sdiIn, ldN};
          else        stage[s] <= stage[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign nowVec = stage[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevVec <= IDLE_VEC;
    else       prevVec <= nowVec;
  end

  always_comb begin
    strobe.shift = nowVec[I_SCLK] & ~prevVec[I_SCLK] & ~nowVec[I_SEL];
    strobe.bitIn = nowVec[I_SDI];
    strobe.load  = prevVec[I_LD] & ~nowVec[I_LD];
  end

  // R3
  load_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !strobe.load);

  // R2
  shift_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> !strobe.shift);
endmodule

// File: rtl/sdac_datapath.sv
module sdac_datapath
  import sdac_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 4,
  parameter int RSV_W  = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           clrN,
  input  logic                           clrSel,
  input  strobe_t                        strobe,
  output logic [NUM_CH-1:0][DATA_W-1:0]  chanOut
);
  localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int WORD_W = ADDR_W + RSV_W + DATA_W;
  localparam logic [DATA_W-1:0] MID_VAL = DATA_W'(1) << (DATA_W-1);

  logic [WORD_W-1:0] shiftReg;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dataField;
  logic [DATA_W-1:0] preset;
  logic              clearN;

  assign addr      = shiftReg[WORD_W-1 -: ADDR_W];
  assign dataField = shiftReg[DATA_W-1:0];
  assign preset    = clrSel ? MID_VAL : '0;
  assign clearN    = rstN & clrN;

  // Shift register: cleared only by power-on reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strobe.shift) shiftReg <= {shiftReg[WORD_W-2:0], strobe.bitIn};
  end

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_chan
      always_ff @(posedge clk or negedge clearN) begin
        if (!clearN)                                   chanOut[c] <= preset;
        else if (strobe.load && addr == ADDR_W'(c))    chanOut[c] <= dataField;
      end

      // R4
      other_chan_hold_chk: assert property (@(posedge clk) disable iff (!clearN)
        (strobe.load && addr != ADDR_W'(c)) |=> $stable(chanOut[c]));

      // R3
      load_write_chk: assert property (@(posedge clk) disable iff (!clearN)
        (strobe.load && addr == ADDR_W'(c)) |=> chanOut[c] == $past(dataField));

      // R5
      clear_preset_chk: assert property (@(posedge clk) disable iff (!rstN)
        !clrN |-> chanOut[c] == (clrSel ? MID_VAL : '0));
    end
  endgenerate

  // R6
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shift |=> $stable(shiftReg));
endmodule

// File: rtl/sdac_quad_if.sv
module sdac_quad_if
  import sdac_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int NUM_CH      = 4,
  parameter int RSV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sclkIn,
  input  logic                          selN,
  input  logic                          sdiIn,
  input  logic                          ldN,
  input  logic                          clrN,
  input  logic                          clrSel,
  output logic [NUM_CH-1:0][DATA_W-1:0] chanOut
);
  strobe_t strobe;

  sdac_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .selN(selN),
    .sdiIn(sdiIn), .ldN(ldN), .strobe(strobe)
  );

  sdac_datapath #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .RSV_W(RSV_W)) u_dp (
    .clk(clk), .rstN(rstN), .clrN(clrN), .clrSel(clrSel),
    .strobe(strobe), .chanOut(chanOut)
  );
endmodule

// File: tb/sim_sdac_quad_if.sv
`timescale 1ns/1ps
module sim_sdac_quad_if;
  logic clk = 0, rstN = 0, sclkIn = 0, selN = 1, sdiIn = 0, ldN = 1, clrN = 1, clrSel = 1;
  logic [3:0][11:0] chanOut;
  logic [15:0] expShift;
  logic [11:0] expChan [4];
  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  sdac_quad_if u0 (.clk(clk), .rstN(rstN), .sclkIn(sclkIn), .selN(selN), .sdiIn(sdiIn),
                   .ldN(ldN), .clrN(clrN), .clrSel(clrSel), .chanOut(chanOut));

  function automatic logic [11:0] presetOf(input logic sel);
    return sel ? 12'h800 : 12'h000;
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    for (int i = 0; i < 4; i++) check(req, chanOut[i], expChan[i]);
  endtask

  task automatic shiftBit(input logic b, input logic counted);
    sdiIn = b; sclkIn = 0; waitClk(4);
    sclkIn = 1; waitClk(4);
    sclkIn = 0;
    if (counted) expShift = {expShift[14:0], b};
  endtask

  // R1 R9: send n bits of w, MSB first
  task automatic sendBits(input logic [31:0] w, input int n);
    selN = 0; waitClk(2);
    for (int i = n - 1; i >= 0; i--) shiftBit(w[i], 1'b1);
    waitClk(2); selN = 1; waitClk(2);
  endtask

  // R2: pulses with select high are ignored
  task automatic noisePulses(input int n);
    selN = 1;
    for (int i = 0; i < n; i++) shiftBit(1'($urandom), 1'b0);
  endtask

  task automatic pulseLoad(input logic selLevel, input logic modelIt);
    selN = selLevel; waitClk(2);
    ldN = 0; waitClk(8);
    if (modelIt && clrN) expChan[expShift[15:14]] = expShift[11:0];
    ldN = 1; waitClk(4);
    selN = 1;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    expShift = '0;
    for (int i = 0; i < 4; i++) expChan[i] = presetOf(1'b1);
    waitClk(3);
    // R8: reset state, midscale preset
    checkAll("R8");
    rstN = 1; waitClk(3);
    pulseLoad(1'b1, 1'b1);
    check("R8", chanOut[0], 12'h000);  // shift register was zero
    checkAll("R8");

    // R1 R4: directed write to each channel, reserved bits set
    for (int ch = 0; ch < 4; ch++) begin
      sendBits({16'h0, 2'(ch), 2'b11, 12'(12'h1A5 + ch * 12'h111)}, 16);
      pulseLoad(1'b1, 1'b1);
      check("R1", chanOut[ch], 12'(12'h1A5 + ch * 12'h111));
      checkAll("R4");
    end

    // R2: ignored pulses between shift and load
    sendBits({16'h0, 16'h8ABC}, 16);
    noisePulses(7);
    pulseLoad(1'b1, 1'b1);
    checkAll("R2");

    // R3: load while select low, then hold low (single write)
    sendBits({16'h0, 16'h4321}, 16);
    pulseLoad(1'b0, 1'b1);
    checkAll("R3");

    // R9: long word, last 16 bits count
    sendBits(32'hFFFF_C0F0, 20);
    pulseLoad(1'b1, 1'b1);
    check("R9", chanOut[3], 12'h0F0);
    checkAll("R9");

    // R5 R6: clear to zero, then reload surviving word
    sendBits({16'h0, 16'h5777}, 16);
    clrSel = 0; clrN = 0; #1;
    for (int i = 0; i < 4; i++) check("R5", chanOut[i], 12'h000);
    for (int i = 0; i < 4; i++) expChan[i] = 12'h000;
    waitClk(3); clrN = 1; waitClk(3);
    pulseLoad(1'b1, 1'b1);
    check("R6", chanOut[1], 12'h777);
    checkAll("R6");

    // R7: load during clear (midscale) is lost
    sendBits({16'h0, 16'hE123}, 16);
    clrSel = 1; clrN = 0; #1;
    for (int i = 0; i < 4; i++) check("R5", chanOut[i], 12'h800);
    for (int i = 0; i < 4; i++) expChan[i] = 12'h800;
    waitClk(2);
    pulseLoad(1'b1, 1'b0);
    ldN = 0; waitClk(4);
    clrN = 1; waitClk(8);
    checkAll("R7");
    ldN = 1; waitClk(4);

    // R1 R2 R3 R4: random traffic
    for (int it = 0; it < 30; it++) begin
      int unsigned w = $urandom;
      if ((w & 3) == 0) noisePulses(3);
      sendBits({16'h0, w[31:16]}, 16 + int'(w[1:0]));
      if (w[2]) noisePulses(2);
      pulseLoad(w[3], 1'b1);
      checkAll("R4");
    end
    finishRun();
  end
endmodule